// File: doc/BRIEF.md
# Oversampling Serial Receiver with Show-Ahead Byte Buffer

This block takes an asynchronous serial line and turns it into bytes a host can collect at its own pace. A sample tick is derived from the system clock at eight times the bit rate. The rate is scaled by a 2-bit baud select, which uses the same encoding as the companion transmitter. The line is synchronized first. A falling edge on the synchronized line starts a frame, and the tick divider is re-phased at that edge so that the eight samples of every bit fall inside that bit.

Each bit is decided by counting its high samples. The bit is a one when more than four of the eight samples are high. Data bits arrive least significant first. When the eighth data bit is decided, the byte is pushed into a 256-entry single-clock FIFO unless the FIFO is full. In that case the byte is lost. The stop period is timed out and not checked, and the receiver then waits for the next falling edge.

The host sees the head byte on the read port whenever the data-available flag is high. It pulses the read enable to move on to the next byte.

Top module: `uart_rx_buffered`

## Requirements
- R1: One bit period lasts 8*BASE_DIV*2^baud_sel_i clock cycles (baud_sel_i = 0, 1, 2, 3 selects multipliers 1, 2, 4, 8), and bytes sent at the selected rate are received correctly.
- R2: The line passes through a two-flop synchronizer. A frame begins only on a high-to-low transition of the synchronized line, so a line held high yields no byte.
- R3: Each bit is sampled on eight ticks and reads as 1 only when more than four of those samples are high. Five high samples give 1 and four give 0.
- R4: Eight data bits follow the start bit, the first received bit being bit 0 (least significant) of the byte.
- R5: The stop period (STOP_BITS bit times, default 1) is not checked. A frame whose stop bit is low still delivers its byte, and the next frame is received normally.
- R6: byte_rdy_o pulses high for exactly one clock for each completed byte, including bytes dropped because the buffer is full.
- R7: The buffer is show-ahead. While data_avail_o is high, rd_data_o already shows the oldest unread byte, and a one-cycle rd_en_i moves on to the next byte in arrival order.
- R8: The buffer holds at most 256 bytes. full_o is high at 256, a byte completing while full is discarded, and the 256 stored bytes are unchanged.
- R9: After reset, data_avail_o, full_o and byte_rdy_o are low.
- R10: A read strobe while the buffer is empty has no effect. The next byte received is the next byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_sel_i | input | 2 | Bit-rate scale: period multiplier 2^baud_sel_i |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| rd_en_i | input | 1 | Read strobe, one pulse per byte |
| rd_data_o | output | 8 | Head byte of the buffer (show-ahead) |
| data_avail_o | output | 1 | Buffer holds at least one byte |
| full_o | output | 1 | Buffer holds 256 bytes |
| byte_rdy_o | output | 1 | One-cycle pulse per completed byte |

## Verification
A mis-phased tick or an off-by-one in the sample or bit counter changes the bit decisions. This shows up as a wrong byte on rd_data_o within the same frame. A wrong majority threshold reveals itself only on the shaped bits, where exactly four or five samples are high. FIFO pointer or count faults appear at the read port as bytes out of order, bytes lost, or an early or late full_o. They surface on the first read after the fault, or at the 256th write. A stuck or stretched ready pulse changes the pulse count or width seen by the bench on the very next byte.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int unsigned BASE_DIV = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       restart_i,
  output logic       tick_o
);
  localparam int unsigned CW = $clog2(BASE_DIV * 8) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb lim = CW'((BASE_DIV << sel_i) - 1);
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= lim;  // tick on the next cycle
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assert_restart_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> tick_o);
  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i) |=> !tick_o);
endmodule

// File: rtl/rx_sync.sv
module rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);
  logic meta_q, line_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      line_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_i;
      line_q <= meta_q;
      prev_q <= line_q;
    end
  end

  assign line_o = line_q;
  assign fall_o = prev_q && !line_q;
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned STOP_BITS = 1,
  parameter int unsigned OVS       = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 line_i,
  input  logic                 fall_i,
  output logic                 restart_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 byte_vld_o
);
  localparam int unsigned SW = $clog2(OVS);
  localparam int unsigned OW = $clog2(OVS + 1);
  localparam int unsigned BW = $clog2(DATA_BITS + STOP_BITS + 1);

  rx_state_e            state_q;
  logic [SW-1:0]        scnt_q;
  logic [OW-1:0]        ones_q;
  logic [OW-1:0]        sum;
  logic [BW-1:0]        bcnt_q;
  logic [DATA_BITS-1:0] shreg_q;
  logic                 vld_q;
  logic                 last_smp;
  logic                 bit_val;

  assign sum       = ones_q + {{(OW-1){1'b0}}, line_i};
  assign last_smp  = (scnt_q == SW'(OVS - 1));
  assign bit_val   = (sum > OW'(OVS / 2));  // strict majority
  assign restart_o = (state_q == RX_IDLE) && fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      scnt_q  <= '0;
      ones_q  <= '0;
      bcnt_q  <= '0;
      shreg_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (state_q == RX_IDLE) begin
        if (fall_i) begin
          state_q <= RX_START;
          scnt_q  <= '0;
          ones_q  <= '0;
          bcnt_q  <= '0;
        end
      end else if (tick_i) begin
        scnt_q <= scnt_q + 1'b1;
        ones_q <= last_smp ? '0 : sum;
        if (last_smp) begin
          case (state_q)
            RX_START: begin
              state_q <= RX_DATA;
              bcnt_q  <= '0;
            end
            RX_DATA: begin
              shreg_q <= {bit_val, shreg_q[DATA_BITS-1:1]};
              if (bcnt_q == BW'(DATA_BITS - 1)) begin
                state_q <= RX_STOP;
                bcnt_q  <= '0;
                vld_q   <= 1'b1;
              end else begin
                bcnt_q <= bcnt_q + 1'b1;
              end
            end
            RX_STOP: begin
              if (bcnt_q == BW'(STOP_BITS - 1)) state_q <= RX_IDLE;
              else                              bcnt_q  <= bcnt_q + 1'b1;
            end
            default: state_q <= RX_IDLE;
          endcase
        end
      end
    end
  end

  assign byte_o     = shreg_q;
  assign byte_vld_o = vld_q;

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
  assert_start_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_IDLE && !fall_i) |=> (state_q == RX_IDLE));
  assert_stop_no_check_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_STOP && tick_i && last_smp && bcnt_q == BW'(STOP_BITS - 1))
      |=> (state_q == RX_IDLE));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [AW:0]      count_q;
  logic             push, pop;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == FULL_CNT);
  assign push    = wr_en_i && !full_o;
  assign pop     = rd_en_i && !empty_o;
  assign rd_data_o = mem_q[rd_ptr_q];  // show-ahead head

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);
  assert_drop_when_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && !rd_en_i) |=> ($stable(count_q) && $stable(rd_data_o)));
  assert_head_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !rd_en_i) |=> $stable(rd_data_o));
  assert_empty_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_en_i && !wr_en_i) |=> empty_o);
endmodule

// File: rtl/uart_rx_buffered.sv
module uart_rx_buffered #(
  parameter int unsigned BASE_DIV  = 8,
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned STOP_BITS = 1,
  parameter int unsigned DEPTH     = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           baud_sel_i,
  input  logic                 rx_i,
  input  logic                 rd_en_i,
  output logic [DATA_BITS-1:0] rd_data_o,
  output logic                 data_avail_o,
  output logic                 full_o,
  output logic                 byte_rdy_o
);
  localparam int unsigned OVS = 8;

  logic line, fall, tick, restart, byte_vld, fifo_empty, fifo_full;
  logic [DATA_BITS-1:0] rx_byte;

  rx_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .line_o (line),
    .fall_o (fall)
  );

  rx_tick_gen #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (baud_sel_i),
    .restart_i (restart),
    .tick_o    (tick)
  );

  rx_frame #(.DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS), .OVS(OVS)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .line_i     (line),
    .fall_i     (fall),
    .restart_o  (restart),
    .byte_o     (rx_byte),
    .byte_vld_o (byte_vld)
  );

  rx_fifo #(.WIDTH(DATA_BITS), .DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (byte_vld && !fifo_full),
    .wr_data_i (rx_byte),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .empty_o   (fifo_empty),
    .full_o    (fifo_full)
  );

  assign data_avail_o = !fifo_empty;
  assign full_o       = fifo_full;
  assign byte_rdy_o   = byte_vld;

  assert_avail_after_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_rdy_o |=> data_avail_o);
endmodule

// File: tb/tb_uart_rx_buffered.sv
`timescale 1ns/1ps
module tb_uart_rx_buffered;
  localparam int BASE = 5;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, rd_en = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [7:0] rd_data;
  logic avail, full, rdy;
  int n_chk = 0, n_fail = 0, pulses = 0, wide = 0;
  logic prev_rdy = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_rx_buffered #(.BASE_DIV(BASE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_sel_i(sel), .rx_i(rx), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .data_avail_o(avail), .full_o(full), .byte_rdy_o(rdy)
  );

  always @(negedge clk) begin
    if (rdy) begin
      pulses++;
      if (prev_rdy) wide++;
    end
    prev_rdy = rdy;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bitp();
    return 8 * BASE * (1 << sel);
  endfunction

  task automatic hold(input logic v, input int cyc);
    rx = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop_lvl);
    @(negedge clk);
    hold(1'b0, bitp());
    for (int i = 0; i < 8; i++) hold(b[i], bitp());
    hold(stop_lvl, bitp());
    hold(1'b1, 4);
  endtask

  // bit0 shaped: first_lvl for n clocks, then ~first_lvl
  task automatic send_shaped(input logic [7:0] b, input logic first_lvl, input int n);
    @(negedge clk);
    hold(1'b0, bitp());
    hold(first_lvl, n);
    hold(~first_lvl, bitp() - n);
    for (int i = 1; i < 8; i++) hold(b[i], bitp());
    hold(1'b1, bitp() + 4);
  endtask

  task automatic pop_expect(input string req, input int exp);
    @(negedge clk);
    chk(req, avail, 1);
    chk(req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx = 1'b1;
    rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();  // R9
    do_reset();
    chk("R9 avail", avail, 0);
    chk("R9 full", full, 0);
    chk("R9 rdy", rdy, 0);
  endtask

  task automatic t_idle_high();  // R2
    int p0;
    p0 = pulses;
    hold(1'b1, 600);
    chk("R2 no byte on idle", pulses - p0, 0);
    chk("R2 avail", avail, 0);
  endtask

  task automatic t_basic();  // R4 R7 R6
    int p0;
    logic [7:0] v [4] = '{8'hA5, 8'h3C, 8'h01, 8'h80};
    p0 = pulses;
    for (int i = 0; i < 4; i++) send(v[i], 1'b1);
    chk("R6 pulse count", pulses - p0, 4);
    for (int i = 0; i < 4; i++) pop_expect("R4 R7 order/lsb-first", v[i]);
    @(negedge clk);
    chk("R7 drained", avail, 0);
  endtask

  task automatic t_majority();  // R3
    send_shaped(8'h00, 1'b1, 5 * BASE);
    pop_expect("R3 five high -> 1", 8'h01);
    send_shaped(8'h00, 1'b1, 4 * BASE);
    pop_expect("R3 four high -> 0", 8'h00);
    send_shaped(8'hF0, 1'b0, 5 * BASE);
    pop_expect("R3 five low -> 0", 8'hF0);
  endtask

  task automatic t_stop_ignored();  // R5
    send(8'h6B, 1'b0);
    hold(1'b1, bitp());
    send(8'hD2, 1'b1);
    pop_expect("R5 low stop kept", 8'h6B);
    pop_expect("R5 next frame", 8'hD2);
  endtask

  task automatic t_baud();  // R1
    sel = 2'b01;
    hold(1'b1, 20);
    send(8'h5A, 1'b1);
    pop_expect("R1 sel=1", 8'h5A);
    sel = 2'b11;
    hold(1'b1, 20);
    send(8'hC3, 1'b1);
    pop_expect("R1 sel=3", 8'hC3);
    sel = 2'b00;
    hold(1'b1, 20);
  endtask

  task automatic t_empty_read();  // R10
    @(negedge clk);
    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b0;
    chk("R10 still empty", avail, 0);
    send(8'h99, 1'b1);
    pop_expect("R10 next byte read", 8'h99);
  endtask

  task automatic t_full();  // R8 R6
    int p0;
    do_reset();
    p0 = pulses;
    for (int i = 0; i < 258; i++) send(8'((i * 37 + 11) & 255), 1'b1);
    chk("R8 full flag", full, 1);
    chk("R6 pulses incl dropped", pulses - p0, 258);
    for (int i = 0; i < 256; i++) pop_expect("R8 kept bytes", (i * 37 + 11) & 255);
    @(negedge clk);
    chk("R8 drained", avail, 0);
    chk("R8 full cleared", full, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_high();
    t_basic();
    t_majority();
    t_stop_ignored();
    t_baud();
    t_empty_read();
    t_full();
    chk("R6 pulse width", wide, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule